// File: doc/BRIEF.md
# Sliding-Window Cell Histogram Store

This block holds the orientation histograms of every cell of one pedestrian-detection window (64 pixels wide, 128 pixels tall, so 8 cell columns by 16 cell rows of 8x8-pixel cells, each cell carrying 9 bins). An upstream binning stage writes finished cell histograms by logical cell row and column. A downstream classifier asks for 2x2-cell blocks by block row and column, and it receives the four cell histograms packed into one 36-bin vector one cycle later.

The store is a ring in the horizontal direction. A window-shift command moves the window one cell column to the right by advancing a column pointer. No data moves. The seven columns that the old and new windows share stay in place and are read back under their new logical positions. The single column that drops out of the window becomes logical column 7. Upstream then needs to write only that column before the new window is complete. A block request outside the 7x15 block grid returns an error pulse and no data.

Top module: `cell_hist_ring`

## Requirements
- R1: After reset `blk_valid` and `blk_err` are low, the column pointer is zero and every stored bin reads back as zero.
- R2: A write with `cell_wr` high stores `cell_bins` at logical cell (`cell_row`, `cell_col`). Bin b occupies bits [b*BIN_W +: BIN_W]. Later block reads that cover that cell return the stored value.
- R3: The block at (`blk_row`=r, `blk_col`=c) covers cells (r,c), (r,c+1), (r+1,c) and (r+1,c+1). These appear in `blk_bins` as cell slots 0, 1, 2 and 3, in that order. Slot k occupies bits [k*9*BIN_W +: 9*BIN_W], and the bins within each slot are in ascending order.
- R4: A request with `blk_rd` high and `blk_row` < 15 and `blk_col` < 7 produces exactly one cycle with `blk_valid` high, on the clock after the request. Both `blk_valid` and `blk_err` stay low in any cycle that follows a cycle without a request.
- R5: A request with `blk_row` >= 15 or `blk_col` >= 7 produces `blk_err` high on the following cycle, with `blk_valid` low and `blk_bins` all zero. `blk_err` and `blk_valid` are never high together.
- R6: Each `win_shift` pulse renumbers the window columns. After the shift, logical column c returns the data that logical column c+1 held before it, for c from 0 to 6. The column pointer is unchanged in any cycle without a shift.
- R7: After a shift, logical column 7 maps onto the storage that held the old logical column 0. A write to it replaces only that storage. After 8 shifts the mapping returns to its starting point.
- R8: When a write and a block read touch the same cell in one cycle, the read returns the contents from before the write.
- R9: A write or a read issued in the same cycle as `win_shift` uses the column numbering from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_wr | input | 1 | Cell histogram write strobe |
| cell_row | input | 4 | Logical cell row of the write (0..15) |
| cell_col | input | 3 | Logical cell column of the write (0..7) |
| cell_bins | input | 144 | Nine bins of the cell, bin 0 in the low bits |
| win_shift | input | 1 | Move the window one cell column |
| blk_rd | input | 1 | Block read request |
| blk_row | input | 4 | Block row (valid 0..14) |
| blk_col | input | 3 | Block column (valid 0..6) |
| blk_valid | output | 1 | Block data valid, one cycle after the request |
| blk_err | output | 1 | Request was outside the block grid |
| blk_bins | output | 576 | Four cell histograms of the block |

## Verification
The assertions check the cycle-level handshake on every clock. They confirm that each request is answered on the next cycle, that no answer appears without a request, that an error and valid data never appear together, that an error carries zero data, and that the column pointer moves only on a shift and wraps back to zero. Data correctness can only be shown by the bench's scenarios. These scenarios cover block packing order, the remapping of shared columns after a shift, the overwrite of only the vacated column, the old-data result of a same-cycle write and read, a shift that coincides with a write and a read, and a full eight-shift wrap.

// File: rtl/cell_hist_ring.sv
module cell_hist_ring #(
  parameter int BIN_W   = 16,
  parameter int NBINS   = 9,
  parameter int CELLS_X = 8,
  parameter int CELLS_Y = 16,
  parameter int RW      = $clog2(CELLS_Y),
  parameter int CW      = $clog2(CELLS_X)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cell_wr,
  input  logic [RW-1:0]                cell_row,
  input  logic [CW-1:0]                cell_col,
  input  logic [NBINS*BIN_W-1:0]       cell_bins,
  input  logic                         win_shift,
  input  logic                         blk_rd,
  input  logic [RW-1:0]                blk_row,
  input  logic [CW-1:0]                blk_col,
  output logic                         blk_valid,
  output logic                         blk_err,
  output logic [4*NBINS*BIN_W-1:0]     blk_bins
);
  localparam int NCELL  = CELLS_X * CELLS_Y;
  localparam int CELL_W = NBINS * BIN_W;
  localparam int SW     = $clog2(NCELL);

  logic [CELL_W-1:0] store [NCELL];
  logic [CW-1:0]     base;
  logic [SW-1:0]     wslot;
  logic [SW-1:0]     rslot [4];
  logic [4*CELL_W-1:0] rdata;
  logic              wr_ok, rd_ok;

  function automatic logic [SW-1:0] slot_of(input int r, input int c, input int b);
    return SW'(r * CELLS_X + (c + b) % CELLS_X);
  endfunction

  assign wr_ok = cell_wr && (int'(cell_row) < CELLS_Y) && (int'(cell_col) < CELLS_X);
  assign rd_ok = blk_rd && (int'(blk_row) < CELLS_Y - 1) && (int'(blk_col) < CELLS_X - 1);
  assign wslot = wr_ok ? slot_of(int'(cell_row), int'(cell_col), int'(base)) : '0;

  for (genvar k = 0; k < 4; k++) begin : g_quad
    assign rslot[k] = rd_ok ? slot_of(int'(blk_row) + k / 2, int'(blk_col) + k % 2, int'(base)) : '0;
    assign rdata[k*CELL_W +: CELL_W] = store[rslot[k]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCELL; i++) store[i] <= '0;
      base      <= '0;
      blk_valid <= 1'b0;
      blk_err   <= 1'b0;
      blk_bins  <= '0;
    end else begin
      if (wr_ok) store[wslot] <= cell_bins;
      if (win_shift) base <= (int'(base) == CELLS_X - 1) ? '0 : base + 1'b1;
      blk_valid <= rd_ok;
      blk_err   <= blk_rd && !rd_ok;
      blk_bins  <= rd_ok ? rdata : '0;
    end
  end
endmodule

module cell_hist_ring_chk #(
  parameter int BIN_W   = 16,
  parameter int NBINS   = 9,
  parameter int CELLS_X = 8,
  parameter int CELLS_Y = 16,
  parameter int RW      = $clog2(CELLS_Y),
  parameter int CW      = $clog2(CELLS_X)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     win_shift,
  input logic                     blk_rd,
  input logic [RW-1:0]            blk_row,
  input logic [CW-1:0]            blk_col,
  input logic                     blk_valid,
  input logic                     blk_err,
  input logic [4*NBINS*BIN_W-1:0] blk_bins,
  input logic [CW-1:0]            base
);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(blk_valid && blk_err));
  p_answer_r4: assert property (@(posedge clk) disable iff (!rst_n) blk_rd |=> (blk_valid || blk_err));
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n) !blk_rd |=> (!blk_valid && !blk_err));
  p_row_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_rd && int'(blk_row) >= CELLS_Y - 1) |=> blk_err);
  p_col_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_rd && int'(blk_col) >= CELLS_X - 1) |=> blk_err);
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n) blk_err |-> (blk_bins == '0));
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) !win_shift |=> $stable(base));
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_shift && int'(base) == CELLS_X - 1) |=> (base == '0));
endmodule

bind cell_hist_ring cell_hist_ring_chk #(
  .BIN_W(BIN_W), .NBINS(NBINS), .CELLS_X(CELLS_X), .CELLS_Y(CELLS_Y), .RW(RW), .CW(CW)
) u_chk (.*);

// File: tb/test_cell_hist_ring.sv
module test_cell_hist_ring;
  localparam int BW = 16, NB = 9, CX = 8, CY = 16;
  localparam int CELL_W = NB * BW;

  logic clk = 0, rst_n = 0;
  logic cell_wr = 0, win_shift = 0, blk_rd = 0;
  logic [3:0] cell_row = 0, blk_row = 0;
  logic [2:0] cell_col = 0, blk_col = 0;
  logic [CELL_W-1:0] cell_bins = '0;
  logic blk_valid, blk_err;
  logic [4*CELL_W-1:0] blk_bins;

  always #10 clk = ~clk;

  cell_hist_ring i_cell_hist_ring (.*);

  typedef struct { logic [4*CELL_W-1:0] data; bit err; string tag; } exp_t;
  exp_t q[$];
  logic [CELL_W-1:0] lm [CY][CX];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [CELL_W-1:0] mk(int gen, int r, int c);
    logic [CELL_W-1:0] v;
    for (int b = 0; b < NB; b++) v[b*BW +: BW] = {gen[4:0], r[3:0], c[2:0], b[3:0]};
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [4*CELL_W-1:0] got, logic [4*CELL_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit w, int r, int c, int gen, bit rd, int br, int bc, bit sh, string tag);
    exp_t e;
    logic [CELL_W-1:0] t [CY][CX];
    @(negedge clk);
    cell_wr = w; cell_row = 4'(r); cell_col = 3'(c); cell_bins = mk(gen, r, c);
    blk_rd = rd; blk_row = 4'(br); blk_col = 3'(bc); win_shift = sh;
    if (rd) begin
      e.tag = tag;
      e.data = '0;
      e.err = !(br < CY - 1 && bc < CX - 1);
      if (!e.err)
        for (int k = 0; k < 4; k++) e.data[k*CELL_W +: CELL_W] = lm[br + k/2][bc + k%2];
      q.push_back(e);
    end
    if (w) lm[r][c] = mk(gen, r, c);
    if (sh) begin
      t = lm;
      for (int rr = 0; rr < CY; rr++)
        for (int cc = 0; cc < CX; cc++) lm[rr][cc] = t[rr][(cc + 1) % CX];
    end
  endtask

  task automatic rd(int br, int bc, string tag);
    cyc(0, 0, 0, 0, 1, br, bc, 0, tag);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  always @(posedge clk) begin
    if (rst_n && !done) begin
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(blk_valid == !e.err && blk_err == e.err, {e.tag, " flags"},
              {blk_valid, blk_err}, {!e.err, e.err});
        check(blk_bins == e.data, {e.tag, " data"}, blk_bins, e.data);
      end else begin
        check(!blk_valid && !blk_err, "R4 idle", {blk_valid, blk_err}, '0);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int r = 0; r < CY; r++) for (int c = 0; c < CX; c++) lm[r][c] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!blk_valid && !blk_err, "R1 reset outputs", {blk_valid, blk_err}, '0);
    @(negedge clk); rst_n = 1;
    rd(0, 0, "R1 zero after reset");
    rd(14, 6, "R1 zero corner after reset");
    idle();
    for (int r = 0; r < CY; r++)
      for (int c = 0; c < CX; c++) cyc(1, r, c, 1, 0, 0, 0, 0, "");
    rd(0, 0, "R3 order block 0,0");
    rd(14, 6, "R2 last block");
    rd(3, 2, "R2 mid block");
    idle();
    rd(7, 4, "R4 single response");
    rd(15, 0, "R5 row out of range");
    rd(0, 7, "R5 col out of range");
    rd(15, 7, "R5 both out of range");
    rd(2, 2, "R4 after error");
    cyc(1, 5, 3, 2, 1, 5, 3, 0, "R8 same-cycle old data");
    rd(5, 3, "R8 new data after");
    rd(4, 2, "R8 diagonal neighbour");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "");
    rd(0, 0, "R6 reused column after shift");
    rd(9, 5, "R6 shared columns renumbered");
    for (int r = 0; r < CY; r++) cyc(1, r, 7, 3, 0, 0, 0, 0, "");
    rd(0, 6, "R7 new column written");
    rd(10, 6, "R7 new column lower");
    rd(4, 5, "R7 neighbour untouched");
    cyc(1, 2, 0, 4, 1, 2, 0, 1, "R9 read with shift uses old map");
    rd(2, 0, "R9 write before shift moved");
    rd(1, 6, "R9 wrapped column");
    for (int i = 0; i < CX; i++) cyc(0, 0, 0, 0, 1, i, i % 7, 1, "R7 wrap during shifts");
    rd(0, 0, "R7 after eight shifts");
    rd(13, 3, "R7 after eight shifts mid");
    rd(5, 2, "R2 repeated read");
    idle(); idle();
    finish_run();
  end
endmodule